// File: doc/BRIEF.md
# Parallel Display Bus Strobe Timer

This block drives the control strobes of an 8080-style parallel display bus. A host request (command write, data write or read) starts one bus access. Inside the access a tick counter runs from zero, and every strobe (chip select, write enable, read enable) asserts and releases at tick counts taken from a packed timing configuration. The access ends when the tick counter reaches the programmed cycle length. A read samples the input bus at a programmed access-time tick.

Two chip-select channels each have their own timing words, tick granularity and pin polarities. A channel selector picks the channel that a new request uses. The timing of the chosen channel is latched when the request is accepted, so the host may reprogram either channel while an access runs. A granularity bit stretches every tick to two clock periods, which doubles all programmed times.

Top module: `dbus_strobe_timer`

## Requirements
- R1: A request is accepted on a clock edge where `req_valid` is high, `busy` is low and `chan_sel` is 1 (channel 0) or 2 (channel 1). `chan_sel` values 0 and 3 select no channel and the request is ignored. Requests made while `busy` is high are ignored. `busy` is high from the clock after acceptance until the access ends.
- R2: A tick lasts one clock when the channel's granularity bit is 0 and two clocks when it is 1. An access lasts E ticks, where E = max(cycle length, CS release tick, 1). The cycle length is the read cycle field for reads and the write cycle field otherwise.
- R3: Logical CS is active for ticks t with cs_on <= t < max(cs_off, cs_on + cs_pulse). Only the CS pin of the accepted channel moves.
- R4: Logical WE is active for we_on <= t < we_off during writes (kinds 0, 1 and 3). It is never active during reads.
- R5: Logical RE is active for re_on <= t < re_off during reads (kind 2). It is never active during writes.
- R6: On a read, `rd_data` takes the `bus_din` value present in the first clock of tick acc. It keeps that value until the next read capture. If acc >= E, nothing is captured.
- R7: The logical A0 level is 0 for command writes (kind 0) and 1 for every other kind. It is stable through the access and is held while idle. It is 1 after reset.
- R8: `bus_oe` is high exactly while a write access is busy, and `bus_dout` then carries the request word. `bus_oe` is low for reads and while idle.
- R9: `done` is a one-clock pulse in the clock after the last clock of an access, with `busy` already low.
- R10: Polarity nibble bits are bit0 CS, bit1 WE, bit2 RE and bit3 A0. A bit value of 1 makes the pin equal the logical level, and 0 inverts it. WE, RE and A0 use the nibble of the last accepted channel (channel 0 after reset). Each CS pin uses its own channel's bit.
- R11: The on/off word holds cs_on[3:0], cs_off[9:4], we_on[13:10], we_off[19:14], re_on[23:20] and re_off[29:24]. The cycle word holds we_cyc[5:0], re_cyc[11:6], cs_pulse[17:12] and acc[27:22]. Timing words and granularity are latched at acceptance, and later changes do not affect the running access.
- R12: After reset: `busy`, `done` and `bus_oe` are 0, `rd_data` is 0, and all strobes are inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request |
| req_kind | input | 2 | 0 command write, 1 data write, 2 read, 3 data write |
| req_wdata | input | DATA_W | Write word |
| chan_sel | input | 2 | 0 none, 1 channel 0, 2 channel 1, 3 none |
| ch0_onoff | input | 32 | Channel 0 strobe on/off word |
| ch0_cycle | input | 32 | Channel 0 cycle word |
| ch0_gran | input | 1 | Channel 0 two-clock tick |
| ch0_pol | input | 4 | Channel 0 polarity nibble |
| ch1_onoff | input | 32 | Channel 1 strobe on/off word |
| ch1_cycle | input | 32 | Channel 1 cycle word |
| ch1_gran | input | 1 | Channel 1 two-clock tick |
| ch1_pol | input | 4 | Channel 1 polarity nibble |
| bus_din | input | DATA_W | Bus input for reads |
| busy | output | 1 | Access in progress |
| done | output | 1 | End-of-access pulse |
| cs_pin | output | 2 | Chip-select pins, one per channel |
| we_pin | output | 1 | Write-enable pin |
| re_pin | output | 1 | Read-enable pin |
| a0_pin | output | 1 | Command/data pin |
| bus_dout | output | DATA_W | Driven write word |
| bus_oe | output | 1 | Output enable for the data bus |
| rd_data | output | DATA_W | Captured read word |

## Verification
The hardest case to reach is an access that runs while everything around it changes. For the whole of each access the bench drives new requests on the other channel with a different kind, and it inverts both channels' timing words and granularity bits. A latching fault or a missing busy guard then shows up as a wrong strobe edge or an extra access. The bench sweeps channel, kind, granularity and seven timing sets, including an all-zero set and one where the minimum CS pulse extends the access. It checks every pin in every clock against tick arithmetic. Read capture is tied to one exact clock because the input bus changes to a new value in every clock.

// File: rtl/dbus_pkg.sv
package dbus_pkg;

    localparam int TICK_W = 7;
    localparam int N_CH   = 2;
    localparam int POL_W  = 4;

    typedef enum logic [1:0] {
        XFER_CMD   = 2'd0,
        XFER_DATA  = 2'd1,
        XFER_READ  = 2'd2,
        XFER_SPARE = 2'd3
    } xfer_kind_e;

    typedef struct packed {
        logic [3:0] cs_on;
        logic [5:0] cs_off;
        logic [3:0] we_on;
        logic [5:0] we_off;
        logic [3:0] re_on;
        logic [5:0] re_off;
        logic [5:0] we_cyc;
        logic [5:0] re_cyc;
        logic [5:0] cs_pw;
        logic [5:0] acc;
        logic       gran;
    } strobe_tim_t;

    function automatic strobe_tim_t unpack_tim(input logic [29:0] onoff,
                                               input logic [5:0]  acc,
                                               input logic [17:0] cyc_lo,
                                               input logic        gran);
        strobe_tim_t t;
        t.cs_on  = onoff[3:0];
        t.cs_off = onoff[9:4];
        t.we_on  = onoff[13:10];
        t.we_off = onoff[19:14];
        t.re_on  = onoff[23:20];
        t.re_off = onoff[29:24];
        t.we_cyc = cyc_lo[5:0];
        t.re_cyc = cyc_lo[11:6];
        t.cs_pw  = cyc_lo[17:12];
        t.acc    = acc;
        t.gran   = gran;
        return t;
    endfunction

    function automatic logic [TICK_W-1:0] tmax(input logic [TICK_W-1:0] a,
                                               input logic [TICK_W-1:0] b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic [TICK_W-1:0] w4(input logic [3:0] v);
        return {{(TICK_W-4){1'b0}}, v};
    endfunction

    function automatic logic [TICK_W-1:0] w6(input logic [5:0] v);
        return {{(TICK_W-6){1'b0}}, v};
    endfunction

    function automatic logic [TICK_W-1:0] cs_release(input strobe_tim_t t);
        return tmax(w6(t.cs_off), w4(t.cs_on) + w6(t.cs_pw));
    endfunction

    function automatic logic [TICK_W-1:0] access_len(input strobe_tim_t t,
                                                     input logic rd);
        logic [TICK_W-1:0] cyc;
        cyc = rd ? w6(t.re_cyc) : w6(t.we_cyc);
        return tmax(tmax(cyc, cs_release(t)), {{(TICK_W-1){1'b0}}, 1'b1});
    endfunction

endpackage

// File: rtl/dbus_tick_gen.sv
module dbus_tick_gen
    import dbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              half_rate,
    input  logic [TICK_W-1:0] len,
    output logic              active,
    output logic [TICK_W-1:0] tick,
    output logic              tick_first,
    output logic              last
);
    logic sub_q;
    logic step;

    assign step       = !half_rate || sub_q;
    assign tick_first = !sub_q;
    assign last       = active && step && ((tick + 1'b1) == len);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            tick   <= '0;
            sub_q  <= 1'b0;
        end else if (start) begin
            active <= 1'b1;
            tick   <= '0;
            sub_q  <= 1'b0;
        end else if (active) begin
            if (step) begin
                sub_q <= 1'b0;
                if (last) begin
                    active <= 1'b0;
                    tick   <= '0;
                end else begin
                    tick <= tick + 1'b1;
                end
            end else begin
                sub_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/dbus_strobe_decode.sv
module dbus_strobe_decode
    import dbus_pkg::*;
(
    input  logic              active,
    input  logic [TICK_W-1:0] tick,
    input  logic              tick_first,
    input  strobe_tim_t       tim,
    input  logic              is_read,
    output logic              cs_act,
    output logic              we_act,
    output logic              re_act,
    output logic              sample_now
);
    logic [TICK_W-1:0] cs_end;

    assign cs_end = cs_release(tim);

    always_comb begin
        cs_act     = active && (tick >= w4(tim.cs_on)) && (tick < cs_end);
        we_act     = active && !is_read &&
                     (tick >= w4(tim.we_on)) && (tick < w6(tim.we_off));
        re_act     = active && is_read &&
                     (tick >= w4(tim.re_on)) && (tick < w6(tim.re_off));
        sample_now = active && is_read && tick_first && (tick == w6(tim.acc));
    end
endmodule

// File: rtl/dbus_pin_drive.sv
module dbus_pin_drive
    import dbus_pkg::*;
(
    input  logic                  cs_act,
    input  logic                  we_act,
    input  logic                  re_act,
    input  logic                  a0_lvl,
    input  logic                  ch,
    input  logic [N_CH*POL_W-1:0] pol_flat,
    output logic [N_CH-1:0]       cs_pin,
    output logic                  we_pin,
    output logic                  re_pin,
    output logic                  a0_pin
);
    logic [POL_W-1:0] pol_cur;

    assign pol_cur = ch ? pol_flat[POL_W +: POL_W] : pol_flat[0 +: POL_W];

    for (genvar i = 0; i < N_CH; i++) begin : g_cs
        logic mine;
        assign mine      = cs_act && (ch == i[0]);
        assign cs_pin[i] = ~(mine ^ pol_flat[i*POL_W]);
    end

    assign we_pin = ~(we_act ^ pol_cur[1]);
    assign re_pin = ~(re_act ^ pol_cur[2]);
    assign a0_pin = ~(a0_lvl ^ pol_cur[3]);
endmodule

// File: rtl/dbus_strobe_timer.sv
module dbus_strobe_timer
    import dbus_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        chan_sel,
    input  logic [31:0]       ch0_onoff,
    input  logic [31:0]       ch0_cycle,
    input  logic              ch0_gran,
    input  logic [3:0]        ch0_pol,
    input  logic [31:0]       ch1_onoff,
    input  logic [31:0]       ch1_cycle,
    input  logic              ch1_gran,
    input  logic [3:0]        ch1_pol,
    input  logic [DATA_W-1:0] bus_din,
    output logic              busy,
    output logic              done,
    output logic [1:0]        cs_pin,
    output logic              we_pin,
    output logic              re_pin,
    output logic              a0_pin,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_oe,
    output logic [DATA_W-1:0] rd_data
);
    logic [31:0]        onoff_w [N_CH];
    logic [31:0]        cycle_w [N_CH];
    logic [N_CH-1:0]    gran_w;
    strobe_tim_t        tim_in  [N_CH];
    logic               unused_rsvd;

    assign onoff_w[0] = ch0_onoff;
    assign onoff_w[1] = ch1_onoff;
    assign cycle_w[0] = ch0_cycle;
    assign cycle_w[1] = ch1_cycle;
    assign gran_w     = {ch1_gran, ch0_gran};

    for (genvar i = 0; i < N_CH; i++) begin : g_unpack
        assign tim_in[i] = unpack_tim(onoff_w[i][29:0], cycle_w[i][27:22],
                                      cycle_w[i][17:0], gran_w[i]);
    end

    assign unused_rsvd = ^{ch0_onoff[31:30], ch0_cycle[31:28], ch0_cycle[21:18],
                           ch1_onoff[31:30], ch1_cycle[31:28], ch1_cycle[21:18]};

    logic              sel_ok;
    logic              sel_idx;
    logic              accept;
    logic              req_rd;

    assign sel_ok = (chan_sel == 2'd1) || (chan_sel == 2'd2);
    assign sel_idx = chan_sel[1];
    assign accept = req_valid && !busy && sel_ok;
    assign req_rd = (xfer_kind_e'(req_kind) == XFER_READ);

    strobe_tim_t        tim_q;
    xfer_kind_e         kind_q;
    logic               ch_q;
    logic [DATA_W-1:0]  wdata_q;
    logic               a0_q;
    logic [TICK_W-1:0]  len_q;
    logic [DATA_W-1:0]  rd_q;
    logic               done_q;
    logic               is_read_q;

    assign is_read_q = (kind_q == XFER_READ);

    logic [TICK_W-1:0]  tick;
    logic               tick_first;
    logic               last;
    logic               cs_act, we_act, re_act, sample_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            tim_q   <= '0;
            kind_q  <= XFER_CMD;
            ch_q    <= 1'b0;
            wdata_q <= '0;
            a0_q    <= 1'b1;
            len_q   <= {{(TICK_W-1){1'b0}}, 1'b1};
            rd_q    <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= last;
            if (accept) begin
                tim_q   <= tim_in[sel_idx];
                kind_q  <= xfer_kind_e'(req_kind);
                ch_q    <= sel_idx;
                wdata_q <= req_wdata;
                a0_q    <= (xfer_kind_e'(req_kind) != XFER_CMD);
                len_q   <= access_len(tim_in[sel_idx], req_rd);
            end
            if (sample_now) begin
                rd_q <= bus_din;
            end
        end
    end

    dbus_tick_gen u_tick (
        .clk        (clk),
        .rst        (rst),
        .start      (accept),
        .half_rate  (tim_q.gran),
        .len        (len_q),
        .active     (busy),
        .tick       (tick),
        .tick_first (tick_first),
        .last       (last)
    );

    dbus_strobe_decode u_dec (
        .active     (busy),
        .tick       (tick),
        .tick_first (tick_first),
        .tim        (tim_q),
        .is_read    (is_read_q),
        .cs_act     (cs_act),
        .we_act     (we_act),
        .re_act     (re_act),
        .sample_now (sample_now)
    );

    dbus_pin_drive u_pins (
        .cs_act   (cs_act),
        .we_act   (we_act),
        .re_act   (re_act),
        .a0_lvl   (a0_q),
        .ch       (ch_q),
        .pol_flat ({ch1_pol, ch0_pol}),
        .cs_pin   (cs_pin),
        .we_pin   (we_pin),
        .re_pin   (re_pin),
        .a0_pin   (a0_pin)
    );

    assign done     = done_q;
    assign rd_data  = rd_q;
    assign bus_oe   = busy && !is_read_q;
    assign bus_dout = bus_oe ? wdata_q : '0;
endmodule

// File: rtl/dbus_strobe_timer_chk.sv
module dbus_strobe_timer_chk
    import dbus_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              busy,
    input logic              done,
    input logic              bus_oe,
    input logic              is_read_q,
    input logic              cs_act,
    input logic              we_act,
    input logic              re_act,
    input logic              a0_q,
    input logic [TICK_W-1:0] tick,
    input logic [TICK_W-1:0] len_q
);
    p_start_req_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(req_valid));

    p_tick_bound_r2: assert property (@(posedge clk) disable iff (rst)
        busy |-> (tick < len_q));

    p_cs_idle_r3: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !cs_act);

    p_we_write_only_r4: assert property (@(posedge clk) disable iff (rst)
        (busy && is_read_q) |-> !we_act);

    p_re_read_only_r5: assert property (@(posedge clk) disable iff (rst)
        (busy && !is_read_q) |-> !re_act);

    p_a0_stable_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(a0_q));

    p_oe_busy_r8: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> busy);

    p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
endmodule

bind dbus_strobe_timer dbus_strobe_timer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .busy      (busy),
    .done      (done),
    .bus_oe    (bus_oe),
    .is_read_q (is_read_q),
    .cs_act    (cs_act),
    .we_act    (we_act),
    .re_act    (re_act),
    .a0_q      (a0_q),
    .tick      (tick),
    .len_q     (len_q)
);

// File: tb/dbus_strobe_timer_bench.sv
`timescale 1ns/1ps
module dbus_strobe_timer_bench;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          req_valid;
    logic [1:0]    req_kind;
    logic [DW-1:0] req_wdata;
    logic [1:0]    chan_sel;
    logic [31:0]   ch0_onoff, ch0_cycle, ch1_onoff, ch1_cycle;
    logic          ch0_gran, ch1_gran;
    logic [3:0]    ch0_pol, ch1_pol;
    logic [DW-1:0] bus_din;
    logic          busy, done, we_pin, re_pin, a0_pin, bus_oe;
    logic [1:0]    cs_pin;
    logic [DW-1:0] bus_dout, rd_data;

    int total = 0;
    int bad   = 0;
    int exp_rd = 0;
    int a0_lvl_hold = 1;

    always #5 clk = ~clk;

    dbus_strobe_timer #(.DATA_W(DW)) u_dbus_strobe_timer (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_wdata(req_wdata), .chan_sel(chan_sel),
        .ch0_onoff(ch0_onoff), .ch0_cycle(ch0_cycle), .ch0_gran(ch0_gran), .ch0_pol(ch0_pol),
        .ch1_onoff(ch1_onoff), .ch1_cycle(ch1_cycle), .ch1_gran(ch1_gran), .ch1_pol(ch1_pol),
        .bus_din(bus_din), .busy(busy), .done(done), .cs_pin(cs_pin),
        .we_pin(we_pin), .re_pin(re_pin), .a0_pin(a0_pin),
        .bus_dout(bus_dout), .bus_oe(bus_oe), .rd_data(rd_data)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int pin(input int act, input int pol);
        return (act == pol) ? 1 : 0;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int pat(input int s, input int k);
        return (s * 97 + k * 13 + 3) & 16'hFFFF;
    endfunction

    task automatic run_access(input int n, input int g, input int kind, input int ch);
        int cs_on, cs_off, we_on, we_off, re_on, re_off, we_cyc, re_cyc, cs_pw, acc;
        int cs_end, e_ticks, gclk, seed, a0l;
        logic [31:0] onoff, cyc;
        logic [3:0]  p0, p1, pc;
        if (n == 6) begin
            cs_on = 0; cs_off = 0; we_on = 0; we_off = 0; re_on = 0; re_off = 0;
            we_cyc = 0; re_cyc = 0; cs_pw = 0; acc = 0;
        end else begin
            cs_on  = n % 3;
            we_on  = cs_on + (n % 2);
            we_off = we_on + 1 + (n % 3);
            re_on  = cs_on + 1;
            re_off = re_on + 2 + (n % 2);
            cs_off = imax(we_off, re_off) + (n % 2);
            we_cyc = we_off + (n % 3);
            re_cyc = re_off + 1;
            cs_pw  = (n == 4) ? 9 : 1;
            acc    = re_on + 1 + (n % 2);
        end
        cs_end  = imax(cs_off, cs_on + cs_pw);
        e_ticks = imax(imax((kind == 2) ? re_cyc : we_cyc, cs_end), 1);
        gclk    = g + 1;
        seed    = n * 31 + g * 7 + kind * 3 + ch;
        onoff = {2'b0, 6'(re_off), 4'(re_on), 6'(we_off), 4'(we_on), 6'(cs_off), 4'(cs_on)};
        cyc   = {4'b0, 6'(acc), 4'b0, 6'(cs_pw), 6'(re_cyc), 6'(we_cyc)};
        p0 = 4'((n * 5 + kind + g) & 15);
        p1 = ~p0;
        pc = (ch == 1) ? p1 : p0;
        a0l = (kind == 0) ? 0 : 1;

        ch0_onoff = onoff; ch0_cycle = cyc; ch0_gran = g[0];
        ch1_onoff = onoff; ch1_cycle = cyc; ch1_gran = g[0];
        ch0_pol = p0; ch1_pol = p1;
        chan_sel  = 2'(ch + 1);
        req_kind  = 2'(kind);
        req_wdata = 16'(seed * 211 + 17);
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        for (int k = 0; k < e_ticks * gclk; k++) begin
            int t;
            int cs_a, we_a, re_a;
            t = k / gclk;
            bus_din = 16'(pat(seed, k));
            cs_a = (t >= cs_on && t < cs_end) ? 1 : 0;
            we_a = (kind != 2 && t >= we_on && t < we_off) ? 1 : 0;
            re_a = (kind == 2 && t >= re_on && t < re_off) ? 1 : 0;
            check("R1 busy during access", int'(busy), 1);
            check("R3 cs pin ch0", int'(cs_pin[0]), pin((ch == 0) ? cs_a : 0, int'(p0[0])));
            check("R3 cs pin ch1", int'(cs_pin[1]), pin((ch == 1) ? cs_a : 0, int'(p1[0])));
            check("R4 we pin", int'(we_pin), pin(we_a, int'(pc[1])));
            check("R5 re pin", int'(re_pin), pin(re_a, int'(pc[2])));
            check("R7 a0 pin", int'(a0_pin), pin(a0l, int'(pc[3])));
            check("R8 bus_oe", int'(bus_oe), (kind != 2) ? 1 : 0);
            if (kind != 2) check("R8 bus_dout", int'(bus_dout), int'(req_wdata_q(seed)));
            check("R9 no early done", int'(done), 0);
            if (kind == 2 && k == acc * gclk && acc < e_ticks) exp_rd = pat(seed, k);
            // R11 and R1: scramble config and push a competing request mid-access
            if (k >= 0) begin
                ch0_onoff = ~onoff; ch1_onoff = ~onoff;
                ch0_cycle = ~cyc;   ch1_cycle = ~cyc;
                ch0_gran  = ~g[0];  ch1_gran  = ~g[0];
                chan_sel  = 2'(2 - ch);
                req_kind  = 2'((kind + 1) % 3);
                req_valid = (k < e_ticks * gclk - 2) ? 1'b1 : 1'b0;
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
        check("R9 done pulse", int'(done), 1);
        check("R2 access length busy low", int'(busy), 0);
        check("R6 rd_data", int'(rd_data), exp_rd);
        check("R8 oe idle", int'(bus_oe), 0);
        check("R7 a0 held idle", int'(a0_pin), pin(a0l, int'(pc[3])));
        check("R10 cs idle ch0", int'(cs_pin[0]), pin(0, int'(p0[0])));
        check("R10 cs idle ch1", int'(cs_pin[1]), pin(0, int'(p1[0])));
        check("R10 we idle", int'(we_pin), pin(0, int'(pc[1])));
        @(negedge clk);
        check("R9 done single", int'(done), 0);
        check("R1 no late accept", int'(busy), 0);
        a0_lvl_hold = a0l;
    endtask

    function automatic logic [DW-1:0] req_wdata_q(input int seed);
        return 16'(seed * 211 + 17);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_kind = 2'd0; req_wdata = '0;
        chan_sel = 2'd0; bus_din = '0;
        ch0_onoff = '0; ch0_cycle = '0; ch0_gran = 1'b0; ch0_pol = 4'hF;
        ch1_onoff = '0; ch1_cycle = '0; ch1_gran = 1'b0; ch1_pol = 4'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R12 busy reset", int'(busy), 0);
        check("R12 done reset", int'(done), 0);
        check("R12 oe reset", int'(bus_oe), 0);
        check("R12 rd_data reset", int'(rd_data), 0);
        check("R12 cs pins reset", int'(cs_pin), 2);
        check("R12 we pin reset", int'(we_pin), 0);
        check("R12 re pin reset", int'(re_pin), 0);
        check("R7 a0 reset level", int'(a0_pin), 1);

        ch0_onoff = 32'h0104_1041; ch0_cycle = 32'h0000_0104;
        foreach (chan_sel[i]) begin end
        chan_sel = 2'd0; req_valid = 1'b1;
        @(negedge clk);
        check("R1 sel 0 ignored", int'(busy), 0);
        chan_sel = 2'd3;
        @(negedge clk);
        check("R1 sel 3 ignored", int'(busy), 0);
        req_valid = 1'b0;
        @(negedge clk);
        check("R1 no done when ignored", int'(done), 0);

        for (int n = 0; n < 7; n++)
            for (int g = 0; g < 2; g++)
                for (int kind = 0; kind < 3; kind++)
                    for (int ch = 0; ch < 2; ch++)
                        run_access(n, g, kind, ch);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule